// File: doc/BRIEF.md
# Synchronized single-pulse generator

This block turns a level input that may change at any moment into a pulse exactly one clock period long. The pulse is aligned with the clock. The input passes through a chain of two edge-triggered stages. The registered output fires only for the first cycle in which a 1 has been captured after a captured 0. A level held high for many cycles therefore produces a single pulse, and a new pulse needs a 0 to be captured first.

For comparison, the block also drives two unregistered outputs. Each is the raw input gated with one of the stored samples, so their width and any glitches follow the raw input. One output gates the input with the first stage. It stays high while the input is high after a 1 has been captured. The other gates the input with the inverse of the second stage. It rises with the input and lasts until the second captured 1, so a held input gives one period plus the time before the first edge.

All outputs are vectors of `WIDTH` independent lanes.

Top module: `synced_pulse_gen`

## Requirements
- R1: An active-low asynchronous reset clears both stages at once, without waiting for a clock edge. While reset is held, `za_o` and `zc_o` are 0 and `zb_o` equals `d_i`.
- R2: When a rising edge captures 1 on a lane and the previous edge captured 0, `za_o` of that lane is 1 from that edge until the next edge.
- R3: Each `za_o` pulse lasts exactly one clock period. The number of `za_o` pulses on a lane equals the number of captured 0-to-1 changes on that lane.
- R4: `za_o` changes only just after a rising clock edge. It stays constant while `d_i` toggles between edges.
- R5: A level held at 1 over several edges gives no further `za_o` pulse. A high or low excursion of `d_i` that falls wholly between two edges has no effect on `za_o`.
- R6: `zc_o` equals `d_i` AND the value captured at the most recent edge. After a captured 1 it follows every change of `d_i` until a 0 is captured.
- R7: `zb_o` equals `d_i` AND NOT the value captured two edges ago. A held high input keeps it high until the second edge that captures 1.
- R8: Lanes are independent. Activity on one bit of `d_i` never changes the outputs of another bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | WIDTH | Level inputs, asynchronous to the clock |
| za_o | output | WIDTH | Registered one-period pulse per captured rising level |
| zb_o | output | WIDTH | Raw input gated by NOT second stage |
| zc_o | output | WIDTH | Raw input gated by first stage |

## Verification
The input is driven in four main ways. A level held high over several edges separates the single registered pulse from the two gated outputs, which stay high for longer. Excursions that begin and end between two edges show that `za_o` ignores anything not captured, while the gated outputs glitch with the input. Toggling after a captured 1 shows `zc_o` following the raw input. Alternating captured values show that the registered pulse re-arms after each captured 0, and different patterns on the two lanes, together with a reset asserted between edges, cover lane independence and the immediate clear.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // edge detector phase, encoded as {first_stage, second_stage}
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_FIRST = 2'b10,
    PH_HELD  = 2'b11,
    PH_FALL  = 2'b01
  } phase_e;
endpackage

// File: rtl/sp_dff.sv
module sp_dff #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sp_moore_edge.sv
module sp_moore_edge
  import sp_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q1_o,
  output logic [WIDTH-1:0] q2_o,
  output logic [WIDTH-1:0] za_o
);
  logic [WIDTH-1:0] q1_q, q2_q;

  sp_dff #(.WIDTH(WIDTH)) u_stage1 (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i),  .q_o(q1_q));
  sp_dff #(.WIDTH(WIDTH)) u_stage2 (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(q1_q), .q_o(q2_q));

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    phase_e ph;
    assign ph      = phase_e'({q1_q[i], q2_q[i]});
    assign za_o[i] = (ph == PH_FIRST);

    // R5: a pulse needs a captured 0 right before it
    p_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      za_o[i] |-> !$past(q1_q[i]));
  end

  assign q1_o = q1_q;
  assign q2_o = q2_q;

  p_za_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (za_o & $past(za_o)) == '0);

  p_za_sampled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (za_o & ~$past(d_i)) == '0);
endmodule

// File: rtl/sp_mealy_gates.sv
module sp_mealy_gates #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] q1_i,
  input  logic [WIDTH-1:0] q2_i,
  output logic [WIDTH-1:0] zb_o,
  output logic [WIDTH-1:0] zc_o
);
  assign zb_o = d_i & ~q2_i;
  assign zc_o = d_i & q1_i;

  p_zc_sampled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zc_o & ~$past(d_i)) == '0);
endmodule

// File: rtl/synced_pulse_gen.sv
module synced_pulse_gen #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] za_o,
  output logic [WIDTH-1:0] zb_o,
  output logic [WIDTH-1:0] zc_o
);
  logic [WIDTH-1:0] q1, q2;

  sp_moore_edge #(.WIDTH(WIDTH)) u_moore (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i),
    .q1_o(q1), .q2_o(q2), .za_o(za_o)
  );

  sp_mealy_gates #(.WIDTH(WIDTH)) u_mealy (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i),
    .q1_i(q1), .q2_i(q2), .zb_o(zb_o), .zc_o(zc_o)
  );
endmodule

// File: tb/synced_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module synced_pulse_gen_tb_top;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] za, zb, zc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] hist[$];
  logic [W-1:0] za_at_edge = '0;
  int trans_cnt[W];
  int pulse_cnt[W];

  always #2.5 clk = ~clk;

  synced_pulse_gen #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .d_i(d), .za_o(za), .zb_o(zb), .zc_o(zc)
  );

  function automatic logic [W-1:0] smp(int k);
    return (hist.size() > k) ? hist[k] : '0;
  endfunction

  // reference: history of values captured at rising edges, newest first
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < W; i++)
        if (d[i] && !smp(0)[i]) trans_cnt[i]++;
      hist.push_front(d);
      if (hist.size() > 2) void'(hist.pop_back());
    end
  end

  always @(negedge rst_n) hist.delete();

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(bit post_edge);
    logic [W-1:0] e_za, e_zb, e_zc;
    e_za = smp(0) & ~smp(1);
    e_zc = d & smp(0);
    e_zb = d & ~smp(1);
    chk("R2 za", za, e_za);
    chk("R6 zc", zc, e_zc);
    chk("R7 zb", zb, e_zb);
    if (post_edge) begin
      za_at_edge = za;
      for (int i = 0; i < W; i++) if (za[i]) pulse_cnt[i]++;
    end else begin
      chk("R4 za stable between edges", za, za_at_edge);
    end
  endtask

  task automatic cycle(logic [W-1:0] a, logic [W-1:0] b);
    @(posedge clk);
    #0.4 check_outputs(1'b1);
    #0.5 d = a;
    #0.2 check_outputs(1'b0);
    #0.6 d = b;
    #0.2 check_outputs(1'b0);
  endtask

  initial begin
    for (int i = 0; i < W; i++) begin trans_cnt[i] = 0; pulse_cnt[i] = 0; end
    // R1: reset state with input high
    d = '1;
    #1;
    chk("R1 za in reset", za, '0);
    chk("R1 zc in reset", zc, '0);
    chk("R1 zb follows d in reset", zb, d);
    repeat (3) @(posedge clk);
    #0.5;
    chk("R1 za held in reset", za, '0);
    chk("R1 zc held in reset", zc, '0);
    d = '0;
    @(negedge clk) rst_n = 1'b1;

    // R2 R3 R5: held high on lane 0
    repeat (4) cycle(2'b01, 2'b01);
    repeat (2) cycle(2'b00, 2'b00);
    // R5: excursion between edges, never captured
    cycle(2'b11, 2'b00);
    cycle(2'b00, 2'b00);
    // re-arm after each captured 0
    repeat (3) begin cycle(2'b11, 2'b11); cycle(2'b00, 2'b00); end
    // R6: toggling after a captured 1
    cycle(2'b11, 2'b11);
    repeat (3) cycle(2'b10, 2'b01);
    repeat (2) cycle(2'b01, 2'b11);
    cycle(2'b00, 2'b00);
    // R8: lanes driven with different patterns
    repeat (3) cycle(2'b10, 2'b10);
    repeat (3) cycle(2'b01, 2'b01);
    cycle(2'b00, 2'b00);
    // R1: reset asserted between edges with a captured 1
    cycle(2'b11, 2'b11);
    cycle(2'b11, 2'b11);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.2;
    chk("R1 za async clear", za, '0);
    chk("R1 zc async clear", zc, '0);
    chk("R1 zb equals d after clear", zb, d);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) cycle(2'b11, 2'b11);
    repeat (3) cycle(2'b00, 2'b00);
    // R3: pulse totals against captured rising changes
    for (int i = 0; i < W; i++) begin
      checks++;
      if (pulse_cnt[i] != trans_cnt[i]) begin
        errors++;
        $display("FAIL R3 pulse count lane %0d actual=%0d expected=%0d",
                 i, pulse_cnt[i], trans_cnt[i]);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule